// File: doc/BRIEF.md
# Received Pause Flow Timer

This block keeps the pause count a link partner requested in its most recent valid pause frame, and turns that count into a hold-off for the local transmitter. The frame parser hands over a one-cycle strobe with the 16-bit pause time from the frame. A free-running quantum tick from the MAC, one pulse per 512 bit times, then decrements the count until it reaches zero. While the count is nonzero and receive flow control is enabled, the block tells the transmit MAC not to start another frame.

The count is reloaded on every valid pause frame, whether receive flow control is enabled or not. The enable bit only decides whether a loaded count actually holds transmission off. The hold-off never rises while a frame is on the wire. It waits for the gap between frames and may drop at any time. A synchronous software reset clears the count and the hold-off; it is used after the enable bit has been changed. The asynchronous reset input is released through a two-stage synchronizer inside the block.

Top module: `pause_flow_timer`

## Requirements
- R1: After rst_n is asserted, or after a cycle with sw_rst high, timer_val is 0 and tx_hold is 0.
- R2: When pause_vld is high in a cycle, timer_val equals pause_time after that clock edge, whatever the value of flow_en.
- R3: A pause frame that arrives while the count is running replaces the remaining count. A load in the same cycle as quanta_tick wins over the decrement.
- R4: A quanta_tick with no load lowers a nonzero count by exactly one. A count of zero stays at zero.
- R5: With flow_en high and tx_busy low, tx_hold is 1 exactly when timer_val is nonzero. tx_hold changes at the same clock edge as timer_val.
- R6: A pause frame with pause_time 0 clears tx_hold at the edge that loads it.
- R7: While flow_en is low, tx_hold is 0, even when the count is nonzero.
- R8: While tx_busy is high (a frame is being sent), tx_hold does not rise, but it may fall. A hold that was deferred rises at the first edge with tx_busy low.
- R9: sw_rst takes priority over a pause_vld in the same cycle, and the count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_rst | input | 1 | Synchronous software reset of count and hold-off |
| flow_en | input | 1 | Receive flow control enable: lets a nonzero count hold off transmission |
| pause_vld | input | 1 | One-cycle strobe: a valid pause frame was received |
| pause_time | input | 16 | Pause time field of that frame, in quanta |
| quanta_tick | input | 1 | One pulse per pause quantum (512 bit times) |
| tx_busy | input | 1 | High while the transmit MAC is sending a frame |
| tx_hold | output | 1 | Do not start a new frame |
| timer_val | output | 16 | Current remaining pause count |

## Verification
Two pairs of functions can fall in the same cycle. A frame load can meet a quantum tick, and a software reset can meet a frame load. Both cases are provoked directly from the vector table. The load must win over the tick, so the count shows the new pause time and not that value minus one. The reset must win over the load, so the count shows zero. A third case needs care: a rising hold-off that meets a busy transmitter. The bench keeps tx_busy high across the edge that would raise tx_hold, checks that tx_hold stays low, and checks that it rises at the first edge with tx_busy low.

// File: rtl/pft_pkg.sv
package pft_pkg;
  localparam int unsigned TIMER_W = 16;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/pft_timer.sv
module pft_timer #(
  parameter int unsigned W = pft_pkg::TIMER_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         nxt_nz
);
  logic [W-1:0] cnt_q, cnt_nxt;
  logic         cnt_nz, cnt_en;

  assign cnt_nz = (cnt_q != '0);

  // next-state: software reset, then load, then decrement
  always_comb begin
    cnt_nxt = cnt_q;
    if (sw_rst)
      cnt_nxt = '0;
    else if (load)
      cnt_nxt = load_val;
    else if (tick && cnt_nz)
      cnt_nxt = cnt_q - 1'b1;
  end

  assign cnt_en = sw_rst | load | (tick & cnt_nz);
  assign nxt_nz = (cnt_nxt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;

  a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sw_rst) |=> (cnt_q == $past(load_val)));

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !sw_rst && cnt_q != '0) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));

  a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> (cnt_q == '0));

  a_r9_swrst_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (cnt_q == '0));
endmodule

// File: rtl/pft_gate.sv
module pft_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic flow_en,
  input  logic busy,
  input  logic cnt_nxt_nz,
  output logic hold
);
  logic hold_q, hold_nxt;

  // a rise is only allowed between frames; a fall is allowed any time
  always_comb begin
    hold_nxt = flow_en & cnt_nxt_nz & (~busy | hold_q);
    if (sw_rst)
      hold_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_q <= 1'b0;
    else
      hold_q <= hold_nxt;
  end

  assign hold = hold_q;

  a_r7_disabled_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_en |=> !hold_q);

  a_r8_no_rise_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hold_q) |=> !hold_q);

  a_r1_swrst_clears_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> !hold_q);
endmodule

// File: rtl/pause_flow_timer.sv
module pause_flow_timer #(
  parameter int unsigned W = pft_pkg::TIMER_W,
  parameter int unsigned SYNC_N = pft_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_rst,
  input  logic         flow_en,
  input  logic         pause_vld,
  input  logic [W-1:0] pause_time,
  input  logic         quanta_tick,
  input  logic         tx_busy,
  output logic         tx_hold,
  output logic [W-1:0] timer_val
);
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_s_n;
  logic              nxt_nz;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[SYNC_N-1];

  pft_timer #(.W(W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .sw_rst   (sw_rst),
    .load     (pause_vld),
    .load_val (pause_time),
    .tick     (quanta_tick),
    .cnt      (timer_val),
    .nxt_nz   (nxt_nz)
  );

  pft_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .sw_rst     (sw_rst),
    .flow_en    (flow_en),
    .busy       (tx_busy),
    .cnt_nxt_nz (nxt_nz),
    .hold       (tx_hold)
  );

  a_r5_hold_needs_count: assert property (@(posedge clk) disable iff (!rst_s_n)
    tx_hold |-> (timer_val != '0));

  a_r6_zero_releases: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pause_vld && pause_time == '0) |=> !tx_hold);
endmodule

// File: tb/pause_flow_timer_bench.sv
module pause_flow_timer_bench;
  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst_n, sw_rst, flow_en, pause_vld, quanta_tick, tx_busy;
  logic [W-1:0] pause_time;
  logic         tx_hold;
  logic [W-1:0] timer_val;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pause_flow_timer u_pause_flow_timer (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .flow_en(flow_en),
    .pause_vld(pause_vld), .pause_time(pause_time), .quanta_tick(quanta_tick),
    .tx_busy(tx_busy), .tx_hold(tx_hold), .timer_val(timer_val)
  );

  typedef struct packed {
    logic         srst;
    logic         en;
    logic         busy;
    logic         vld;
    logic         tick;
    logic [15:0]  ptime;
    logic [15:0]  exp_cnt;
    logic         exp_hold;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 15;
  // srst en busy vld tick ptime exp_cnt exp_hold req
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b1,1'b0,16'd3,     16'd3,     1'b1,4'd2}, // R2 R5
    '{1'b0,1'b1,1'b0,1'b0,1'b1,16'd0,     16'd2,     1'b1,4'd4}, // R4
    '{1'b0,1'b1,1'b0,1'b1,1'b1,16'd10,    16'd10,    1'b1,4'd3}, // R3 load beats tick
    '{1'b0,1'b1,1'b0,1'b0,1'b1,16'd0,     16'd9,     1'b1,4'd4}, // R4
    '{1'b0,1'b1,1'b0,1'b1,1'b0,16'd0,     16'd0,     1'b0,4'd6}, // R6
    '{1'b0,1'b1,1'b0,1'b0,1'b1,16'd0,     16'd0,     1'b0,4'd4}, // R4 floor
    '{1'b0,1'b0,1'b0,1'b1,1'b0,16'd5,     16'd5,     1'b0,4'd7}, // R7 R2
    '{1'b0,1'b0,1'b0,1'b0,1'b1,16'd0,     16'd4,     1'b0,4'd7}, // R7
    '{1'b0,1'b1,1'b1,1'b0,1'b0,16'd0,     16'd4,     1'b0,4'd8}, // R8 no rise
    '{1'b0,1'b1,1'b0,1'b0,1'b0,16'd0,     16'd4,     1'b1,4'd8}, // R8 rise in gap
    '{1'b0,1'b1,1'b1,1'b0,1'b1,16'd0,     16'd3,     1'b1,4'd8}, // R8 held in frame
    '{1'b0,1'b1,1'b1,1'b1,1'b0,16'd0,     16'd0,     1'b0,4'd8}, // R8 fall in frame
    '{1'b1,1'b1,1'b0,1'b1,1'b0,16'd7,     16'd0,     1'b0,4'd9}, // R9
    '{1'b0,1'b1,1'b0,1'b1,1'b0,16'hFFFF,  16'hFFFF,  1'b1,4'd5}, // R5 full scale
    '{1'b1,1'b1,1'b0,1'b0,1'b0,16'd0,     16'd0,     1'b0,4'd1}  // R1 software reset
  };

  task automatic check(input string tag, input logic [W-1:0] ec, input logic eh);
    n_run++;
    if (timer_val !== ec || tx_hold !== eh) begin
      n_fail++;
      $display("FAIL %s: timer_val=%0d tx_hold=%0b expected timer_val=%0d tx_hold=%0b",
               tag, timer_val, tx_hold, ec, eh);
    end
  endtask

  task automatic idle();
    sw_rst = 0; pause_vld = 0; quanta_tick = 0; tx_busy = 0; pause_time = '0;
  endtask

  initial begin
    rst_n = 0; flow_en = 1; idle();
    repeat (3) @(negedge clk);
    check("R1 reset", 16'd0, 1'b0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 after release", 16'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      sw_rst = VEC[i].srst; flow_en = VEC[i].en; tx_busy = VEC[i].busy;
      pause_vld = VEC[i].vld; quanta_tick = VEC[i].tick; pause_time = VEC[i].ptime;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp_cnt, VEC[i].exp_hold);
    end

    // R4: count 4 down to zero over ticks, hold tracks it (R5)
    idle(); flow_en = 1; pause_vld = 1; pause_time = 16'd4;
    @(negedge clk); idle();
    for (int k = 3; k >= 0; k--) begin
      quanta_tick = 1; @(negedge clk); quanta_tick = 0;
      check("R4 countdown", 16'(k), k != 0);
      @(negedge clk);
      check("R4 no tick, no change", 16'(k), k != 0);
    end

    // R1: asynchronous reset mid-count
    pause_vld = 1; pause_time = 16'd20; @(negedge clk); idle();
    check("R2 reload", 16'd20, 1'b1);
    #1 rst_n = 0; #1;
    check("R1 async reset", 16'd0, 1'b0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 stays cleared", 16'd0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule